// File: doc/BRIEF.md
# Disk Controller Interrupt Status Logic

This block keeps track of why a floppy-style disk controller wants attention and reports the reason when the host issues a sense-interrupt status command. Two kinds of cause are tracked. A polling cause is raised when a read, write, format or verify style command reaches its result phase, or when a non-DMA transfer needs a data byte. A seek cause is raised per drive when a seek, relative seek or recalibrate finishes, normally or abnormally. The interrupt line stays high while any cause is pending.

Each sense-interrupt command consumes one cause and returns a two-byte result: a status byte (ST0) and the cylinder the reported drive sits on. Seek causes are served before the polling cause, lowest drive first. A drive that starts a seek stays busy until the sense command has reported its completion. A powerdown-exit pulse clears every pending cause, every busy flag and every stored cylinder.

Top module: `fdc_irq_status`

## Requirements
- R1: While reset is high, the next clock edge leaves `irq` low, `drv_busy` all zero and `res_valid` low.
- R2: A pulse on any bit of `rw_evt` or on `ndma_req` sets the polling cause and raises `irq` after that edge. The next sense that serves it returns ST0 = 0xC0 | drive (IC=11 in bits 7:6, SE=0 in bit 5), where drive is the `evt_drv` value from the latest such pulse. It also returns that drive's stored cylinder.
- R3: A `seek_done` pulse on drive d with `seek_abn` low stores `pcn_in` for d and raises `irq`. Serving it returns ST0 = 0x20 | d (IC=00, SE=1) and the stored cylinder.
- R4: The same pulse with `seek_abn` high is served as ST0 = 0x60 | d (IC=01, SE=1).
- R5: In every sense result, ST0 bit 2 (head address) and bits 4:3 read 0, and bits 1:0 hold the reported drive.
- R6: `drv_busy[d]` rises on the edge after `seek_start[d]`. It stays high through the completion and clears on the edge of the sense command that reports drive d.
- R7: Pending seek causes are served one per sense in ascending drive order, ahead of the polling cause. `irq` stays high until the last pending cause has been served.
- R8: A sense command with nothing pending returns ST0 = 0x80 (IC=10) and cylinder 0.
- R9: A `pwr_exit` pulse clears all pending causes, all busy flags and all stored cylinders. On the next edge `irq` is low, and later reports show cylinder 0 until a new completion stores one.
- R10: A new cause that arrives in the same cycle as a sense command is kept pending and is not lost, even when the sense consumes another cause.
- R11: `res_valid` is high for exactly the cycle after each `sense_cmd` pulse, with `res_st0` and `res_pcn` valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rw_evt | input | NRW | Result-phase entry strobes, one per read/write/format/verify command type |
| ndma_req | input | 1 | Non-DMA data byte request strobe |
| evt_drv | input | DRV_W | Drive number that goes with a polling event |
| seek_start | input | ND | Seek-family command started, one bit per drive |
| seek_done | input | ND | Seek-family command finished, one bit per drive |
| seek_abn | input | ND | Qualifies `seek_done`: abnormal termination |
| pcn_in | input | ND*CYL_W | Present cylinder per drive, drive 0 in the low bits |
| pwr_exit | input | 1 | Powerdown exit pulse |
| sense_cmd | input | 1 | Sense-interrupt status command strobe |
| irq | output | 1 | Interrupt request, high while any cause is pending |
| drv_busy | output | ND | Per-drive busy flag |
| res_valid | output | 1 | Result bytes valid |
| res_st0 | output | 8 | Status byte of the result |
| res_pcn | output | CYL_W | Cylinder byte of the result |

## Verification
The case that most needs watching is a sense command consuming one cause in the same cycle that a completion strobe raises another. The clear and the set then reach the pending registers on one edge. The bench holds a seek cause on drive 0, then pulses `sense_cmd` together with `seek_done` for drive 2. It expects drive 0 to be reported first, `irq` to remain high afterwards, and a following sense to report drive 2 with the cylinder captured in that shared cycle.

// File: rtl/fdc_irq_pkg.sv
package fdc_irq_pkg;
  typedef enum logic [1:0] {
    IC_NORMAL   = 2'b00,
    IC_ABNORMAL = 2'b01,
    IC_INVALID  = 2'b10,
    IC_POLL     = 2'b11
  } ic_e;

  // Status byte layout: [7:6] cause code, [5] seek end, [4:3] zero,
  // [2] head address (always zero here), [1:0] drive number.
  function automatic logic [7:0] st0_pack(ic_e ic, logic se, logic [1:0] ds);
    return {ic, se, 3'b000, ds};
  endfunction
endpackage

// File: rtl/fdc_seek_slot.sv
module fdc_seek_slot #(
  parameter int CYL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_all,
  input  logic             start,
  input  logic             done,
  input  logic             abn,
  input  logic [CYL_W-1:0] pcn_in,
  input  logic             ack,
  output logic             pend,
  output logic             abn_q,
  output logic             busy,
  output logic [CYL_W-1:0] pcn_q
);
  always_ff @(posedge clk) begin
    if (rst || clr_all) begin
      pend  <= 1'b0;
      abn_q <= 1'b0;
      busy  <= 1'b0;
      pcn_q <= '0;
    end else begin
      if (done)      pend <= 1'b1;
      else if (ack)  pend <= 1'b0;
      if (done)      abn_q <= abn;
      if (done)      pcn_q <= pcn_in;
      if (start)     busy <= 1'b1;
      else if (ack)  busy <= 1'b0;
    end
  end
endmodule

// File: rtl/fdc_sense_arbiter.sv
module fdc_sense_arbiter #(
  parameter int ND    = 4,
  parameter int DRV_W = 2
) (
  input  logic [ND-1:0]    seek_pend,
  input  logic             poll_pend,
  output logic             sel_seek,
  output logic             sel_poll,
  output logic [DRV_W-1:0] sel_idx
);
  always_comb begin
    sel_seek = 1'b0;
    sel_idx  = '0;
    for (int i = ND - 1; i >= 0; i--) begin
      if (seek_pend[i]) begin
        sel_seek = 1'b1;
        sel_idx  = DRV_W'(i);
      end
    end
    sel_poll = !sel_seek && poll_pend;
  end
endmodule

// File: rtl/fdc_irq_status.sv
module fdc_irq_status #(
  parameter int ND    = 4,
  parameter int CYL_W = 8,
  parameter int NRW   = 8,
  localparam int DRV_W = (ND > 1) ? $clog2(ND) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NRW-1:0]      rw_evt,
  input  logic                ndma_req,
  input  logic [DRV_W-1:0]    evt_drv,
  input  logic [ND-1:0]       seek_start,
  input  logic [ND-1:0]       seek_done,
  input  logic [ND-1:0]       seek_abn,
  input  logic [ND*CYL_W-1:0] pcn_in,
  input  logic                pwr_exit,
  input  logic                sense_cmd,
  output logic                irq,
  output logic [ND-1:0]       drv_busy,
  output logic                res_valid,
  output logic [7:0]          res_st0,
  output logic [CYL_W-1:0]    res_pcn
);
  import fdc_irq_pkg::*;

  logic [ND-1:0]    seek_pend;
  logic [ND-1:0]    seek_abn_q;
  logic [ND-1:0]    seek_ack;
  logic [CYL_W-1:0] pcn_arr [ND];
  logic             poll_pend;
  logic [DRV_W-1:0] poll_drv;
  logic             sel_seek, sel_poll;
  logic [DRV_W-1:0] sel_idx;
  logic             poll_evt;

  assign poll_evt = (|rw_evt) || ndma_req;

  for (genvar d = 0; d < ND; d++) begin : g_slot
    assign seek_ack[d] = sense_cmd && sel_seek && (sel_idx == DRV_W'(d));
    fdc_seek_slot #(.CYL_W(CYL_W)) u_slot (
      .clk    (clk),
      .rst    (rst),
      .clr_all(pwr_exit),
      .start  (seek_start[d]),
      .done   (seek_done[d]),
      .abn    (seek_abn[d]),
      .pcn_in (pcn_in[d*CYL_W +: CYL_W]),
      .ack    (seek_ack[d]),
      .pend   (seek_pend[d]),
      .abn_q  (seek_abn_q[d]),
      .busy   (drv_busy[d]),
      .pcn_q  (pcn_arr[d])
    );
  end

  fdc_sense_arbiter #(.ND(ND), .DRV_W(DRV_W)) u_arb (
    .seek_pend(seek_pend),
    .poll_pend(poll_pend),
    .sel_seek (sel_seek),
    .sel_poll (sel_poll),
    .sel_idx  (sel_idx)
  );

  // Polling cause: set wins over the clear of a concurrent sense.
  always_ff @(posedge clk) begin
    if (rst || pwr_exit) begin
      poll_pend <= 1'b0;
      poll_drv  <= '0;
    end else if (poll_evt) begin
      poll_pend <= 1'b1;
      poll_drv  <= evt_drv;
    end else if (sense_cmd && sel_poll) begin
      poll_pend <= 1'b0;
    end
  end

  assign irq = (|seek_pend) || poll_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_st0   <= '0;
      res_pcn   <= '0;
    end else begin
      res_valid <= sense_cmd;
      if (sense_cmd) begin
        if (sel_seek) begin
          res_st0 <= st0_pack(seek_abn_q[sel_idx] ? IC_ABNORMAL : IC_NORMAL,
                              1'b1, 2'(sel_idx));
          res_pcn <= pcn_arr[sel_idx];
        end else if (sel_poll) begin
          res_st0 <= st0_pack(IC_POLL, 1'b0, 2'(poll_drv));
          res_pcn <= pcn_arr[poll_drv];
        end else begin
          res_st0 <= st0_pack(IC_INVALID, 1'b0, 2'b00);
          res_pcn <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/fdc_irq_status_chk.sv
module fdc_irq_status_chk #(
  parameter int ND    = 4,
  parameter int CYL_W = 8,
  parameter int NRW   = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [NRW-1:0]   rw_evt,
  input logic             ndma_req,
  input logic [ND-1:0]    seek_start,
  input logic             pwr_exit,
  input logic             sense_cmd,
  input logic             irq,
  input logic [ND-1:0]    drv_busy,
  input logic             res_valid,
  input logic [7:0]       res_st0,
  input logic [CYL_W-1:0] res_pcn
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!irq && !res_valid && drv_busy == '0));

  a_r2_event_raises_irq: assert property (@(posedge clk) disable iff (rst)
    ((|rw_evt) || ndma_req) && !pwr_exit |=> irq);

  a_r5_fixed_zero_bits: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_st0[4:2] == 3'b000));

  a_r6_start_sets_busy: assert property (@(posedge clk) disable iff (rst)
    (|seek_start) && !pwr_exit |=> ((drv_busy & $past(seek_start)) == $past(seek_start)));

  a_r8_invalid_zero_cyl: assert property (@(posedge clk) disable iff (rst)
    res_valid && res_st0[7:6] == 2'b10 |-> (res_pcn == '0 && !res_st0[5]));

  a_r9_powerdown_clears: assert property (@(posedge clk) disable iff (rst)
    pwr_exit |=> (!irq && drv_busy == '0));

  a_r11_valid_after_sense: assert property (@(posedge clk) disable iff (rst)
    sense_cmd |=> res_valid);

  a_r11_valid_only_after_sense: assert property (@(posedge clk) disable iff (rst)
    !sense_cmd |=> !res_valid);
endmodule

bind fdc_irq_status fdc_irq_status_chk #(.ND(ND), .CYL_W(CYL_W), .NRW(NRW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rw_evt    (rw_evt),
  .ndma_req  (ndma_req),
  .seek_start(seek_start),
  .pwr_exit  (pwr_exit),
  .sense_cmd (sense_cmd),
  .irq       (irq),
  .drv_busy  (drv_busy),
  .res_valid (res_valid),
  .res_st0   (res_st0),
  .res_pcn   (res_pcn)
);

// File: tb/fdc_irq_status_bench.sv
`timescale 1ns/100ps
module fdc_irq_status_bench;
  localparam int ND = 4, CYL_W = 8, NRW = 8, DRV_W = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic [NRW-1:0] rw_evt = '0;
  logic ndma_req = 1'b0;
  logic [DRV_W-1:0] evt_drv = '0;
  logic [ND-1:0] seek_start = '0, seek_done = '0, seek_abn = '0;
  logic [ND*CYL_W-1:0] pcn_in = '0;
  logic pwr_exit = 1'b0, sense_cmd = 1'b0;
  logic irq, res_valid;
  logic [ND-1:0] drv_busy;
  logic [7:0] res_st0;
  logic [CYL_W-1:0] res_pcn;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;
  logic [15:0] exp_q [$];
  string tag_q [$];

  always #2.5 clk = ~clk;

  fdc_irq_status #(.ND(ND), .CYL_W(CYL_W), .NRW(NRW)) u_fdc_irq_status (
    .clk(clk), .rst(rst), .rw_evt(rw_evt), .ndma_req(ndma_req), .evt_drv(evt_drv),
    .seek_start(seek_start), .seek_done(seek_done), .seek_abn(seek_abn),
    .pcn_in(pcn_in), .pwr_exit(pwr_exit), .sense_cmd(sense_cmd),
    .irq(irq), .drv_busy(drv_busy), .res_valid(res_valid),
    .res_st0(res_st0), .res_pcn(res_pcn)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Advance to the next falling edge and drop all strobes.
  task automatic step();
    @(negedge clk);
    rw_evt = '0; ndma_req = 1'b0; seek_start = '0; seek_done = '0;
    seek_abn = '0; pwr_exit = 1'b0; sense_cmd = 1'b0;
  endtask

  task automatic sense(string tag, logic [7:0] st0, logic [7:0] cyl);
    exp_q.push_back({st0, cyl});
    tag_q.push_back(tag);
    sense_cmd = 1'b1;
    step();
    chk("R11 valid pulse", 16'(res_valid), 16'd1);
    step();
    chk("R11 valid one cycle", 16'(res_valid), 16'd0);
  endtask

  task automatic seek_end(int d, bit abn, logic [7:0] cyl);
    seek_done[d] = 1'b1;
    seek_abn[d]  = abn;
    pcn_in[d*CYL_W +: CYL_W] = cyl;
  endtask

  // Monitor: pop expected result and compare as results appear.
  always @(negedge clk) begin
    if (!rst && res_valid) begin
      if (exp_q.size() == 0) begin
        chk("R11 unexpected result", {res_st0, res_pcn}, 16'hxxxx);
      end else begin
        automatic logic [15:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(t, {res_st0, res_pcn}, e);
        chk("R5 head bit", 16'(res_st0[2]), 16'd0);
      end
    end
  end

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 irq", 16'(irq), 16'd0);
    chk("R1 busy", 16'(drv_busy), 16'd0);
    chk("R1 valid", 16'(res_valid), 16'd0);
    rst = 1'b0;
    step();

    // R8 nothing pending
    sense("R8 empty sense", 8'h80, 8'h00);

    // R6 + R3 normal seek on drive 1
    seek_start[1] = 1'b1; step();
    chk("R6 busy set", 16'(drv_busy), 16'h0002);
    repeat (3) step();
    seek_end(1, 1'b0, 8'h25); step();
    chk("R3 irq on seek end", 16'(irq), 16'd1);
    chk("R6 busy held", 16'(drv_busy), 16'h0002);
    sense("R3 normal seek d1", 8'h21, 8'h25);
    chk("R6 busy cleared", 16'(drv_busy), 16'h0000);
    chk("R3 irq cleared", 16'(irq), 16'd0);

    // R4 abnormal seek on drive 2
    seek_end(2, 1'b1, 8'h10); step();
    sense("R4 abnormal seek d2", 8'h62, 8'h10);

    // R2 result-phase entry and non-DMA request
    rw_evt[3] = 1'b1; evt_drv = 2'd3; step();
    chk("R2 irq on result phase", 16'(irq), 16'd1);
    sense("R2 poll d3", 8'hC3, 8'h00);
    ndma_req = 1'b1; evt_drv = 2'd1; step();
    sense("R2 poll d1 ndma", 8'hC1, 8'h25);

    // R7 ordering: seeks ascending, then poll
    seek_end(3, 1'b0, 8'h07); seek_end(0, 1'b0, 8'h09);
    rw_evt[7] = 1'b1; evt_drv = 2'd2; step();
    sense("R7 first d0", 8'h20, 8'h09);
    chk("R7 irq held 1", 16'(irq), 16'd1);
    sense("R7 second d3", 8'h23, 8'h07);
    chk("R7 irq held 2", 16'(irq), 16'd1);
    sense("R7 third poll d2", 8'hC2, 8'h10);
    chk("R7 irq drops", 16'(irq), 16'd0);

    // R10 sense coincides with new completion
    seek_end(0, 1'b0, 8'h0B); step();
    exp_q.push_back(16'h200B); tag_q.push_back("R10 served d0");
    sense_cmd = 1'b1; seek_end(2, 1'b0, 8'h33);
    step();
    chk("R10 valid", 16'(res_valid), 16'd1);
    chk("R10 irq kept", 16'(irq), 16'd1);
    step();
    sense("R10 kept d2", 8'h22, 8'h33);

    // R9 powerdown exit
    seek_start[3] = 1'b1; step();
    seek_end(1, 1'b0, 8'h44); step();
    chk("R9 irq before", 16'(irq), 16'd1);
    pwr_exit = 1'b1; step();
    chk("R9 irq cleared", 16'(irq), 16'd0);
    chk("R9 busy cleared", 16'(drv_busy), 16'd0);
    sense("R9 nothing left", 8'h80, 8'h00);
    ndma_req = 1'b1; evt_drv = 2'd1; step();
    sense("R9 cylinder cleared", 8'hC1, 8'h00);

    repeat (3) step();
    chk("R11 all results seen", 16'(exp_q.size()), 16'd0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule